// File: doc/BRIEF.md
# Interrupt Redirection and End-of-Interrupt Engine

This block takes up to 24 interrupt lines and turns each one into an outgoing interrupt message. Each pin has a programmable redirection entry and a request bit. A pin whose request is pending and whose entry is unmasked is offered on a valid/ready message port. The lowest-numbered pin wins, and at most one message leaves per cycle. Each message has an address word and a data word. The address word carries the destination index and the destination mode. The data word carries the vector, the delivery mode and the trigger mode.

Edge pins latch a rising edge and drop the request once their message is taken. Level pins follow the line. When a level pin sends, it sets a remote-pending bit, and no further message leaves that pin until an end-of-interrupt broadcast with a matching vector clears the bit. If that broadcast finds the request still pending, the pin is delivered again and a per-pin re-trigger counter advances. When the counter reaches its limit, the pin is held back for a programmable number of cycles. This limits interrupt storms.

Top module: `irq_redirect_engine`

## Requirements
- R1: After reset every entry is masked, all request, remote-pending and hold-back state is clear, and `msgValid` is low.
- R2: A pin is offered only while its request bit is set and its entry's mask bit is clear. Clearing the mask of a pending pin makes it offered on the next cycle.
- R3: An edge pin sets its request on a rising line edge only. The request clears at the clock edge where its message is accepted (`msgValid` and `msgReady` both high).
- R4: A level pin's request follows its line. Acceptance of its message sets remote-pending. While remote-pending is set, the pin offers no further message, even with the line held high.
- R5: `msgAddr` = 0xFEE00000, OR the destination index shifted left by 4, OR the logical-destination bit shifted left by 2.
- R6: `msgData` = vector in bits [7:0], delivery mode in bits [10:8], level-trigger bit in bit 15, all other bits zero.
- R7: Among offered pins the lowest index is presented. The message holds while `msgReady` is low, and one message is accepted per cycle.
- R8: An EOI strobe clears remote-pending on every level entry whose vector equals `eoiVector`. A matched entry that is unmasked with its request still pending is offered again on the next cycle, and its re-trigger counter increments. An EOI with no matching vector changes nothing.
- R9: When a matched EOI would bring a pin's counter to `STORM_LIMIT`, the counter resets and the pin is withheld. If the hold timer is idle, it loads `holdoffCycles` and counts down once per cycle. Withheld pins are released at the first clock edge that finds the timer at zero. A matched EOI on a pin that is not pending, or any entry write to the pin, clears its counter. Writing an edge entry clears remote-pending.
- R10: Line 0 drives pin 2, together with line 2. Pin 0 has no source. Every other line drives the pin of the same index.
- R11: Delivery mode 3'b111 takes the message vector from `extVector` instead of from the entry.
- R12: `cfgEntry` layout: [7:0] vector, [10:8] delivery mode, [11] logical destination, [12] level trigger, [13] mask, [29:14] destination index. A write with `cfgIdx` at or above the pin count is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqLines | input | 24 | Interrupt input lines |
| cfgWrEn | input | 1 | Entry write strobe |
| cfgIdx | input | 5 | Entry index for the write |
| cfgEntry | input | 30 | New entry contents |
| extVector | input | 8 | Vector used by the external delivery mode |
| eoiValid | input | 1 | End-of-interrupt broadcast strobe |
| eoiVector | input | 8 | Vector being acknowledged |
| holdoffCycles | input | 16 | Hold-back length after a storm |
| msgValid | output | 1 | Message offered |
| msgReady | input | 1 | Message accepted this cycle |
| msgAddr | output | 32 | Message address word |
| msgData | output | 32 | Message data word |

## Verification
A stuck remote-pending bit shows as a level pin that never re-sends after a matching EOI, or one that re-sends without an EOI. Either appears on `msgValid` one cycle after the broadcast. A wrong re-trigger count moves the hold-back window by a whole EOI round trip. A wrong timer moves the release edge by one or more cycles, and the bench catches this at the exact cycle. Table corruption appears as a wrong address or data word the first time the affected pin is presented. A reference model compares every cycle, so any divergence is reported at the cycle where it first reaches the port.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int PIN_COUNT = 24;
  localparam int PIN_IDX_W = $clog2(PIN_COUNT);
  localparam int REDIR_W   = 30;
  localparam logic [2:0]  DM_EXTERNAL = 3'b111;
  localparam logic [31:0] MSG_BASE    = 32'hFEE0_0000;

  typedef struct packed {
    logic [15:0] destIdx;
    logic        masked;
    logic        levelTrig;
    logic        logicalDest;
    logic [2:0]  delivMode;
    logic [7:0]  vector;
  } redir_t;

  typedef struct packed {
    logic                 fire;
    logic [PIN_IDX_W-1:0] pick;
  } strobe_t;
endpackage

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_route_pkg::*;
#(
  parameter int PINS = PIN_COUNT
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cfgWrEn,
  input  logic [$clog2(PINS)-1:0]    cfgIdx,
  input  redir_t                     cfgEntry,
  input  logic [7:0]                 extVector,
  input  strobe_t                    stb,
  output logic [PINS-1:0]            maskVec,
  output logic [PINS-1:0]            levelVec,
  output logic [7:0]                 vecTbl [PINS],
  output logic [31:0]                msgAddr,
  output logic [31:0]                msgData
);
  localparam int IDX_W = $clog2(PINS);

  redir_t tbl [PINS];
  redir_t sel;
  logic [7:0] selVector;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < PINS; i++) begin
        tbl[i]        <= '0;
        tbl[i].masked <= 1'b1;
      end
    end else if (cfgWrEn) begin
      for (int i = 0; i < PINS; i++)
        if (cfgIdx == IDX_W'(i)) tbl[i] <= cfgEntry;
    end
  end

  always_comb begin
    for (int i = 0; i < PINS; i++) begin
      maskVec[i]  = tbl[i].masked;
      levelVec[i] = tbl[i].levelTrig;
      vecTbl[i]   = tbl[i].vector;
    end
  end

  always_comb begin
    sel       = tbl[stb.pick];
    selVector = (sel.delivMode == DM_EXTERNAL) ? extVector : sel.vector;
    msgAddr   = MSG_BASE | {12'h0, sel.destIdx, 4'h0} | {29'h0, sel.logicalDest, 2'b00};
    msgData   = {16'h0, sel.levelTrig, 4'h0, sel.delivMode, selVector};
  end

  p_addr_base_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.fire |-> (msgAddr[31:20] == 12'hFEE && msgAddr[1:0] == 2'b00));
  p_data_pad_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.fire |-> (msgData[31:16] == 16'h0 && msgData[14:11] == 4'h0));
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_route_pkg::*;
#(
  parameter int PINS        = PIN_COUNT,
  parameter int STORM_LIMIT = 4,
  parameter int HOLD_W      = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [PINS-1:0]         irqLines,
  input  logic                    cfgWrEn,
  input  logic [$clog2(PINS)-1:0] cfgIdx,
  input  logic                    cfgLevel,
  input  logic [PINS-1:0]         maskVec,
  input  logic [PINS-1:0]         levelVec,
  input  logic [7:0]              vecTbl [PINS],
  input  logic                    eoiValid,
  input  logic [7:0]              eoiVector,
  input  logic [HOLD_W-1:0]       holdoffCycles,
  input  logic                    msgReady,
  output logic                    msgValid,
  output strobe_t                 stb
);
  localparam int IDX_W = $clog2(PINS);
  localparam int CNT_W = $clog2(STORM_LIMIT + 1);

  logic [PINS-1:0] mapped, prevMapped, irr, remoteIrr, deferred;
  logic [PINS-1:0] eligible, eoiHit, wrHit, sendHere, stormNow;
  logic [CNT_W-1:0] stormCnt [PINS];
  logic [HOLD_W-1:0] holdTimer;
  logic releaseAll;

  // Line-to-pin routing: line 0 lands on pin 2, pin 0 is unused
  genvar g;
  generate
    for (g = 0; g < PINS; g++) begin : gPin
      if (g == 0) begin : gNone
        assign mapped[g] = 1'b0;
      end else if (g == 2) begin : gShared
        assign mapped[g] = irqLines[0] | irqLines[2];
      end else begin : gDirect
        assign mapped[g] = irqLines[g];
      end
      assign eoiHit[g]   = eoiValid && levelVec[g] && (vecTbl[g] == eoiVector);
      assign wrHit[g]    = cfgWrEn && (cfgIdx == IDX_W'(g));
      assign eligible[g] = irr[g] && !maskVec[g] && !(levelVec[g] && remoteIrr[g]) && !deferred[g];
      assign sendHere[g] = stb.fire && (stb.pick == IDX_W'(g));
      assign stormNow[g] = eoiHit[g] && !wrHit[g] && !maskVec[g] && irr[g]
                           && (int'(stormCnt[g]) + 1 >= STORM_LIMIT);
    end
  endgenerate

  always_comb begin
    stb.pick = '0;
    for (int i = PINS - 1; i >= 0; i--)
      if (eligible[i]) stb.pick = IDX_W'(i);
    msgValid = |eligible;
    stb.fire = msgValid && msgReady;
  end

  assign releaseAll = (holdTimer == '0) && !(|stormNow) && (|deferred);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irr        <= '0;
      remoteIrr  <= '0;
      deferred   <= '0;
      prevMapped <= '0;
      holdTimer  <= '0;
      for (int i = 0; i < PINS; i++) stormCnt[i] <= '0;
    end else begin
      prevMapped <= mapped;
      for (int i = 0; i < PINS; i++) begin
        irr[i] <= levelVec[i] ? mapped[i]
                              : ((irr[i] && !sendHere[i]) || (mapped[i] && !prevMapped[i]));
        if (wrHit[i] && !cfgLevel)          remoteIrr[i] <= 1'b0;
        else if (sendHere[i] && levelVec[i]) remoteIrr[i] <= 1'b1;
        else if (eoiHit[i])                  remoteIrr[i] <= 1'b0;
        if (wrHit[i])
          stormCnt[i] <= '0;
        else if (eoiHit[i]) begin
          if (!maskVec[i] && irr[i]) stormCnt[i] <= stormNow[i] ? '0 : stormCnt[i] + 1'b1;
          else                       stormCnt[i] <= '0;
        end
        deferred[i] <= stormNow[i] || (deferred[i] && !releaseAll);
      end
      if (holdTimer != '0)  holdTimer <= holdTimer - 1'b1;
      else if (|stormNow)   holdTimer <= holdoffCycles;
    end
  end

  p_fire_ok_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.fire |-> (irr[stb.pick] && !maskVec[stb.pick]));
  p_edge_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.fire && !levelVec[stb.pick] && !(mapped[stb.pick] && !prevMapped[stb.pick]))
    |=> !irr[$past(stb.pick)]);
  p_level_latch_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.fire && levelVec[stb.pick] && !(wrHit[stb.pick] && !cfgLevel))
    |=> remoteIrr[$past(stb.pick)]);
  p_no_defer_send_r9: assert property (@(posedge clk) disable iff (!rstN)
    stb.fire |-> !deferred[stb.pick]);
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    int'(stormCnt[stb.pick]) < STORM_LIMIT);
endmodule

// File: rtl/irq_redirect_engine.sv
module irq_redirect_engine
  import irq_route_pkg::*;
#(
  parameter int PINS        = PIN_COUNT,
  parameter int STORM_LIMIT = 4,
  parameter int HOLD_W      = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [PINS-1:0]         irqLines,
  input  logic                    cfgWrEn,
  input  logic [$clog2(PINS)-1:0] cfgIdx,
  input  logic [REDIR_W-1:0]      cfgEntry,
  input  logic [7:0]              extVector,
  input  logic                    eoiValid,
  input  logic [7:0]              eoiVector,
  input  logic [HOLD_W-1:0]       holdoffCycles,
  output logic                    msgValid,
  input  logic                    msgReady,
  output logic [31:0]             msgAddr,
  output logic [31:0]             msgData
);
  redir_t          newEntry;
  strobe_t         stb;
  logic [PINS-1:0] maskVec, levelVec;
  logic [7:0]      vecTbl [PINS];

  assign newEntry = redir_t'(cfgEntry);

  irq_ctrl #(.PINS(PINS), .STORM_LIMIT(STORM_LIMIT), .HOLD_W(HOLD_W)) uCtrl (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .cfgWrEn(cfgWrEn), .cfgIdx(cfgIdx),
    .cfgLevel(newEntry.levelTrig), .maskVec(maskVec), .levelVec(levelVec), .vecTbl(vecTbl),
    .eoiValid(eoiValid), .eoiVector(eoiVector), .holdoffCycles(holdoffCycles),
    .msgReady(msgReady), .msgValid(msgValid), .stb(stb));

  irq_datapath #(.PINS(PINS)) uData (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgIdx(cfgIdx), .cfgEntry(newEntry),
    .extVector(extVector), .stb(stb), .maskVec(maskVec), .levelVec(levelVec),
    .vecTbl(vecTbl), .msgAddr(msgAddr), .msgData(msgData));
endmodule

// File: tb/sim_irq_redirect_engine.sv
`timescale 1ns/1ps
module sim_irq_redirect_engine;
  localparam int NP = 24;
  localparam int LIM = 4;

  logic clk = 0, rstN = 0;
  logic [NP-1:0] irqLines = '0;
  logic cfgWrEn = 0, eoiValid = 0, msgReady = 1;
  logic [4:0] cfgIdx = '0;
  logic [29:0] cfgEntry = '0;
  logic [7:0] extVector = '0, eoiVector = '0;
  logic [15:0] holdoffCycles = 16'd10;
  logic msgValid;
  logic [31:0] msgAddr, msgData;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  irq_redirect_engine u0 (.clk(clk), .rstN(rstN), .irqLines(irqLines), .cfgWrEn(cfgWrEn),
    .cfgIdx(cfgIdx), .cfgEntry(cfgEntry), .extVector(extVector), .eoiValid(eoiValid),
    .eoiVector(eoiVector), .holdoffCycles(holdoffCycles), .msgValid(msgValid),
    .msgReady(msgReady), .msgAddr(msgAddr), .msgData(msgData));

  // ---------------- behavioural reference ----------------
  logic [29:0] mT [NP];
  logic [NP-1:0] mIrr, mRem, mDef, mPrev;
  int mCnt [NP];
  int mTmr;

  function automatic bit lineFor(int i);
    if (i == 0) return 1'b0;
    if (i == 2) return irqLines[0] | irqLines[2];
    return irqLines[i];
  endfunction

  function automatic int pickPin();
    for (int i = 0; i < NP; i++)
      if (mIrr[i] && !mT[i][13] && !(mT[i][12] && mRem[i]) && !mDef[i]) return i;
    return -1;
  endfunction

  function automatic logic [31:0] refAddr(int p);
    return 32'hFEE0_0000 | ({16'h0, mT[p][29:14]} << 4) | (32'(mT[p][11]) << 2);
  endfunction

  function automatic logic [31:0] refData(int p);
    logic [7:0] v;
    v = (mT[p][10:8] == 3'b111) ? extVector : mT[p][7:0];
    return {24'h0, v} | (32'(mT[p][10:8]) << 8) | (32'(mT[p][12]) << 15);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NP; i++) begin mT[i] = 30'h2000; mCnt[i] = 0; end
      mIrr = '0; mRem = '0; mDef = '0; mPrev = '0; mTmr = 0;
    end else begin
      int p;
      bit fire, anyStorm;
      logic [NP-1:0] oIrr, oDef, storm;
      p = pickPin();
      fire = (p >= 0) && msgReady;
      oIrr = mIrr; oDef = mDef; storm = '0;
      for (int i = 0; i < NP; i++) begin
        bit lvl, hit, wr, snd, cur;
        lvl = mT[i][12]; cur = lineFor(i);
        hit = eoiValid && lvl && (mT[i][7:0] == eoiVector);
        wr  = cfgWrEn && (int'(cfgIdx) == i);
        snd = fire && (p == i);
        mIrr[i] = lvl ? cur : ((oIrr[i] && !snd) || (cur && !mPrev[i]));
        if (wr && !cfgEntry[12]) mRem[i] = 0;
        else if (snd && lvl)     mRem[i] = 1;
        else if (hit)            mRem[i] = 0;
        if (wr) mCnt[i] = 0;
        else if (hit) begin
          if (!mT[i][13] && oIrr[i]) begin
            if (mCnt[i] + 1 >= LIM) begin mCnt[i] = 0; storm[i] = 1; end
            else mCnt[i] = mCnt[i] + 1;
          end else mCnt[i] = 0;
        end
        mPrev[i] = cur;
      end
      anyStorm = |storm;
      if (mTmr != 0) mTmr = mTmr - 1;
      else if (anyStorm) mTmr = int'(holdoffCycles);
      else if (|oDef) oDef = '0;
      mDef = oDef | storm;
      if (cfgWrEn && int'(cfgIdx) < NP) mT[cfgIdx] = cfgEntry;
    end
  end

  // cycle-by-cycle comparison (R2/R7 presence, R5/R6 words)
  always @(negedge clk) begin
    if (rstN && !finished) begin
      int p;
      p = pickPin();
      total++;
      if (msgValid !== (p >= 0)) begin
        bad++; $display("FAIL R2/R7 valid got=%0b exp=%0b t=%0t", msgValid, p >= 0, $time);
      end else if (p >= 0) begin
        total++;
        if (msgAddr !== refAddr(p) || msgData !== refData(p)) begin
          bad++;
          $display("FAIL R5/R6 words got=%h/%h exp=%h/%h t=%0t", msgAddr, msgData,
                   refAddr(p), refData(p), $time);
        end
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  function automatic logic [29:0] mk(logic [15:0] d, bit msk, bit lvl, bit lg,
                                     logic [2:0] dm, logic [7:0] v);
    return {d, msk, lvl, lg, dm, v};
  endfunction

  task automatic prog(int idx, logic [29:0] e);
    cfgWrEn = 1; cfgIdx = 5'(idx); cfgEntry = e;
    step(1);
    cfgWrEn = 0;
  endtask

  task automatic eoi(logic [7:0] v);
    eoiValid = 1; eoiVector = v;
    step(1);
    eoiValid = 0;
  endtask

  task automatic expect1(string tag, bit v, logic [31:0] a, logic [31:0] d, bit chkA);
    @(negedge clk);
    total++;
    if (msgValid !== v) begin
      bad++; $display("FAIL %s valid got=%0b exp=%0b", tag, msgValid, v);
    end else if (v) begin
      total++;
      if (msgData !== d || (chkA && msgAddr !== a)) begin
        bad++; $display("FAIL %s got=%h/%h exp=%h/%h", tag, msgAddr, msgData, a, d);
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    expect1("R1 idle after reset", 0, 0, 0, 0);
    irqLines[4] = 1; step(2);
    expect1("R1 reset entries masked", 0, 0, 0, 0);
    irqLines[4] = 0;

    // R3/R5/R6 edge pin 5
    prog(5, mk(16'h0012, 0, 0, 0, 3'd0, 8'h31));
    irqLines[5] = 1; step(1);
    expect1("R3 R5 R6 edge message", 1, 32'hFEE0_0120, 32'h0000_0031, 1);
    step(1);
    expect1("R3 request cleared on accept", 0, 0, 0, 0);
    step(2);
    expect1("R3 held line gives no repeat", 0, 0, 0, 0);
    irqLines[5] = 0;

    // R4/R8/R9 level pin 9
    prog(9, mk(16'h0003, 0, 1, 1, 3'd0, 8'h40));
    irqLines[9] = 1; step(1);
    expect1("R4 R5 R6 level message", 1, 32'hFEE0_0034, 32'h0000_8040, 1);
    step(1);
    expect1("R4 coalesced while remote pending", 0, 0, 0, 0);
    step(3);
    expect1("R4 still coalesced", 0, 0, 0, 0);
    eoi(8'h41);
    expect1("R8 non-matching EOI ignored", 0, 0, 0, 0);
    for (int k = 0; k < LIM - 1; k++) begin
      eoi(8'h40);
      expect1("R8 re-delivery after EOI", 1, 32'hFEE0_0034, 32'h0000_8040, 1);
      step(1);
    end
    eoi(8'h40);
    expect1("R9 storm withholds pin", 0, 0, 0, 0);
    step(10);
    expect1("R9 still withheld at timer zero", 0, 0, 0, 0);
    step(1);
    expect1("R9 released after hold-back", 1, 32'hFEE0_0034, 32'h0000_8040, 1);
    step(1);
    irqLines[9] = 0; step(1);
    eoi(8'h40);
    expect1("R8 EOI with line low sends nothing", 0, 0, 0, 0);

    // R7 priority and hold under back-pressure
    prog(3, mk(16'h0, 0, 0, 0, 3'd0, 8'h23));
    prog(7, mk(16'h0, 0, 0, 0, 3'd0, 8'h27));
    msgReady = 0; irqLines[3] = 1; irqLines[7] = 1; step(1);
    expect1("R7 lowest index first", 1, 0, 32'h23, 0);
    step(2);
    expect1("R7 held while not ready", 1, 0, 32'h23, 0);
    msgReady = 1; step(1);
    expect1("R7 next pin after accept", 1, 0, 32'h27, 0);
    step(1);
    expect1("R7 queue drained", 0, 0, 0, 0);
    irqLines[3] = 0; irqLines[7] = 0;

    // R10 routing of line 0
    prog(2, mk(16'h0, 0, 0, 0, 3'd0, 8'h52));
    prog(0, mk(16'h0, 0, 0, 0, 3'd0, 8'h50));
    irqLines[0] = 1; step(1);
    expect1("R10 line 0 reaches pin 2", 1, 0, 32'h52, 0);
    step(1);
    expect1("R10 pin 0 silent", 0, 0, 0, 0);
    irqLines[0] = 0;

    // R11 external vector mode
    extVector = 8'h9A;
    prog(11, mk(16'h0, 0, 0, 0, 3'b111, 8'h11));
    irqLines[11] = 1; step(1);
    expect1("R11 vector from port", 1, 32'hFEE0_0000, 32'h0000_079A, 1);
    step(1); irqLines[11] = 0;

    // R2 mask gating
    prog(12, mk(16'h0, 1, 1, 0, 3'd0, 8'h60));
    irqLines[12] = 1; step(2);
    expect1("R2 masked pin not offered", 0, 0, 0, 0);
    prog(12, mk(16'h0, 0, 1, 0, 3'd0, 8'h60));
    expect1("R2 unmask releases pending pin", 1, 0, 32'h8060, 0);
    step(1); irqLines[12] = 0;

    // R12 out-of-range write ignored
    prog(30, mk(16'h0, 0, 0, 0, 3'd0, 8'h66));
    irqLines[6] = 1; step(2);
    expect1("R12 write beyond pin count ignored", 0, 0, 0, 0);
    irqLines[6] = 0; step(2);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1; bad++; total++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule